// File: doc/BRIEF.md
# Configurable PAL Output Macrocell

This block is one output cell of a small programmable logic device. It receives the OR-sum of a product-term array. A two-bit mode word sets two things: whether the pin value comes from a flip-flop that captured the sum or comes straight from the sum, and whether the pin is active high or active low. The cell drives a pin value and a separate output-enable line. The pad's tri-state driver sits outside the block.

A one-bit feedback select chooses the signal that goes back into the array. It is either the cell's own output value or the level seen on the external pin. When the pin is not driven, the external level comes from whatever the board places on it. The mode word and the feedback select are static configuration inputs. They may change at any time without touching the stored register bit.

Top module: `pal_out_cell`

## Requirements
- R1: While `rst_n` is low the register holds 0. As a result, mode 01 shows 0 on `pin_o` and mode 00 shows 1.
- R2: On every rising clock edge outside reset, the register loads `sum_in`. `pin_o` in a registered mode changes only after that edge.
- R3: Mode 00 (registered, active low) drives `pin_o` with the inverse of the register.
- R4: Mode 01 (registered, active high) drives `pin_o` with the register value.
- R5: Mode 10 (combinational, active low) drives `pin_o` with the inverse of `sum_in` in the same cycle.
- R6: Mode 11 (combinational, active high) drives `pin_o` with `sum_in` in the same cycle.
- R7: `pin_oe` equals `oe` at all times. `pin_o` keeps its mode-defined value whether or not the pad is enabled.
- R8: With `fb_sel` = 0, `fb_o` equals the cell output `pin_o`.
- R9: With `fb_sel` = 1, `fb_o` equals `pin_i`, whatever the value of `oe`.
- R10: A change of `mode` between clock edges does not alter the stored register bit. Returning to a registered mode shows the value captured at the last edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the register samples on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sum_in | input | 1 | OR-sum from the product-term array |
| oe | input | 1 | Output enable for the pad |
| mode | input | 2 | Bit 1: 0 registered, 1 combinational; bit 0: 0 active low, 1 active high |
| fb_sel | input | 1 | Feedback source: 0 cell output, 1 external pin |
| pin_i | input | 1 | Level present on the external pin |
| pin_o | output | 1 | Value to drive onto the pin |
| pin_oe | output | 1 | Pad driver enable |
| fb_o | output | 1 | Feedback into the array |

## Verification
On every cycle, the assertions check the following:
- the register load on each edge;
- the mapping from each of the four modes to the pin value;
- the output-enable pass-through;
- both feedback sources.

Other behaviours can only be shown by the bench's scenarios:
- the reset values as seen at the pin in both registered polarities;
- that a registered output waits for the edge;
- that switching modes between edges leaves the stored bit intact.

// File: rtl/pal_out_cell.sv
module pal_out_cell (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sum_in,
  input  logic       oe,
  input  logic [1:0] mode,
  input  logic       fb_sel,
  input  logic       pin_i,
  output logic       pin_o,
  output logic       pin_oe,
  output logic       fb_o
);

  logic q;
  logic core;

  // R1, R2: register loads the sum, cleared by reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= sum_in;
  end

  // mode[1] picks path, mode[0] picks polarity (R3-R6 encodings)
  assign core   = mode[1] ? sum_in : q;
  assign pin_o  = mode[0] ? core : ~core;
  assign pin_oe = oe;
  assign fb_o   = fb_sel ? pin_i : pin_o;

endmodule

// File: rtl/pal_out_cell_chk.sv
module pal_out_cell_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sum_in,
  input logic       oe,
  input logic [1:0] mode,
  input logic       fb_sel,
  input logic       pin_i,
  input logic       pin_o,
  input logic       pin_oe,
  input logic       fb_o,
  input logic       q
);

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> q == $past(sum_in));

  a_r3_reg_low: assert property (@(negedge clk) disable iff (!rst_n)
    mode == 2'b00 |-> pin_o == !q);

  a_r4_reg_high: assert property (@(negedge clk) disable iff (!rst_n)
    mode == 2'b01 |-> pin_o == q);

  a_r5_comb_low: assert property (@(negedge clk) disable iff (!rst_n)
    mode == 2'b10 |-> pin_o == !sum_in);

  a_r6_comb_high: assert property (@(negedge clk) disable iff (!rst_n)
    mode == 2'b11 |-> pin_o == sum_in);

  a_r7_oe: assert property (@(negedge clk) disable iff (!rst_n)
    pin_oe == oe);

  a_r8_fb_cell: assert property (@(negedge clk) disable iff (!rst_n)
    !fb_sel |-> fb_o == pin_o);

  a_r9_fb_pin: assert property (@(negedge clk) disable iff (!rst_n)
    fb_sel |-> fb_o == pin_i);

endmodule

bind pal_out_cell pal_out_cell_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sum_in(sum_in), .oe(oe), .mode(mode),
  .fb_sel(fb_sel), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe),
  .fb_o(fb_o), .q(q)
);

// File: tb/tb_pal_out_cell.sv
module tb_pal_out_cell;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sum_in = 1'b0, oe = 1'b0, fb_sel = 1'b0, pin_i = 1'b0;
  logic [1:0] mode = 2'b01;
  logic pin_o, pin_oe, fb_o;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  pal_out_cell dut (
    .clk(clk), .rst_n(rst_n), .sum_in(sum_in), .oe(oe), .mode(mode),
    .fb_sel(fb_sel), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe), .fb_o(fb_o)
  );

  // {mode, sum_in, oe, fb_sel, pin_i, exp pin_o, exp fb_o}: combinational modes
  localparam logic [7:0] VEC [8] = '{
    8'b11_1_1_0_0_1_1,  // R6, R8
    8'b11_0_1_0_1_0_0,  // R6, R8
    8'b10_1_1_0_0_0_0,  // R5, R8
    8'b10_0_0_0_0_1_1,  // R5, R7
    8'b11_1_0_1_0_1_0,  // R9 with pad off
    8'b10_1_0_1_1_0_1,  // R9 with pad off
    8'b11_0_1_1_1_0_1,  // R9
    8'b10_0_1_1_0_1_0   // R9
  };

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state seen through both registered polarities
    sum_in = 1'b1;
    repeat (2) @(negedge clk);
    #1 check("R1 mode01", pin_o, 1'b0);
    mode = 2'b00;
    #1 check("R1 mode00", pin_o, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    mode = 2'b01;
    #1 check("R2 before edge", pin_o, 1'b0);
    @(posedge clk);
    #1 check("R2 after edge", pin_o, 1'b1);
    check("R4", pin_o, 1'b1);
    mode = 2'b00;
    #1 check("R3", pin_o, 1'b0);
    check("R8 registered", fb_o, 1'b0);

    // R10: mode changes between edges keep the stored bit
    @(negedge clk);
    mode = 2'b11; sum_in = 1'b0;
    #1 check("R10 comb view", pin_o, 1'b0);
    mode = 2'b01;
    #1 check("R10 stored kept", pin_o, 1'b1);
    @(posedge clk);
    #1 check("R2 load zero", pin_o, 1'b0);

    // R5-R9 vector table
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      {mode, sum_in, oe, fb_sel, pin_i} = VEC[i][7:2];
      #1;
      check("R5/R6 pin", pin_o, VEC[i][1]);
      check("R8/R9 fb", fb_o, VEC[i][0]);
      check("R7 oe", pin_oe, oe);
    end

    // R2, R4 after table: registered view of last loaded sum (0)
    @(negedge clk);
    mode = 2'b01; sum_in = 1'b1; oe = 1'b0; fb_sel = 1'b0;
    #1 check("R2 holds prior", pin_o, 1'b0);
    check("R7 pad off value", pin_o, 1'b0);
    @(posedge clk);
    #1 check("R4 new load", pin_o, 1'b1);
    check("R8 registered high", fb_o, 1'b1);

    // R1 again: asynchronous clear mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R1 async clear", pin_o, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule